// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Word-Boundary Slip

This block gathers a one-bit serial stream, sampled on a fast bit clock, into six-bit parallel words on a slow word clock. The word clock runs at one sixth of the bit rate and has a fixed phase relation to the bit clock. Each bit clock edge on which the internal enable is high pushes the serial input into a history register. Each rising edge of the word clock then copies six consecutive history bits into the registered output word.

Downstream framing logic trains for alignment by pulsing a slip request. Each word-clock cycle with the request high moves the word boundary by one bit position, and the offset wraps after six moves.

The internal enable has two modes, selected by a parameter. In single-enable mode the first enable input gates the capture directly. In dual-enable mode both enable inputs are registered on the word clock and then share the word period: the first covers the half in which the word clock is high, and the second covers the half in which it is low.

Top module: `bitslip_deser`

## Requirements
- R1: The output `q` is 6 bits wide and is registered on each rising edge of `clk_word`. With a slip offset of o, `q[i]` is the serial bit that entered the history i+o enabled bit-clock edges before that word-clock edge. As a result, the earliest of six bits received in order lands on `q[5]` and the latest on `q[0]`.
- R2: `bitslip` is active high and is sampled on rising edges of `clk_word`. Each sampled-high edge advances the slip offset by one, and the word captured on that same edge already uses the new offset. For a period-6 stream, the word at offset o is the offset-0 word rotated right by o positions.
- R3: The slip offset counts modulo 6, so six requests bring back the original word.
- R4: With `NUM_CE` = 1, the internal enable equals `en_a`, and `en_b` has no effect on the output.
- R5: With `NUM_CE` = 2, `en_a` and `en_b` are registered on rising edges of `clk_word`. The internal enable takes the registered `en_a` while `clk_word` is high and the registered `en_b` while it is low.
- R6: The two enable registers of the dual mode are cleared to 0 asynchronously by `rst`. As a result, no bit enters during the low half of the word period that follows reset release.
- R7: On a bit-clock edge with the internal enable low, the history register holds. While the enable stays low and no slip is requested, `q` stays constant.
- R8: A high level on `rst` synchronously clears the history register, the slip offset and `q` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Fast serial bit clock |
| clk_word | input | 1 | Slow word clock, one sixth of the bit rate |
| rst | input | 1 | Active-high reset |
| din | input | 1 | Serial data input |
| en_a | input | 1 | First enable input (direct enable in single mode, high-half enable in dual mode) |
| en_b | input | 1 | Second enable input (low-half enable in dual mode, ignored in single mode) |
| bitslip | input | 1 | Word-boundary slip request, one step per sampled-high word cycle |
| q | output | 6 | Registered parallel word, earliest bit on the most significant position |

## Verification
The bench builds two copies side by side with a word width of 6: one with `NUM_CE` = 2 and one with `NUM_CE` = 1. Both copies share one serial stream and one set of control inputs. This lets each enable pattern show its effect in both modes at once.

For three repeating patterns, the bench sweeps all six slip offsets and the wrap back to zero. It compares each offset against an arithmetic rotation of the offset-0 word. The dual copy is driven with each enable held off on its own half of the word period, which exposes the half-period split and the cleared enable registers after reset.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // History holds two words so that any of the six alignments is a contiguous slice.
  localparam int unsigned HIST_WORDS = 2;

  // Step a counter by one and wrap at the given period.
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned period);
    return (cur + 1 >= period) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/deser_enable.sv
module deser_enable #(
  parameter int unsigned NUM_CE = 2
) (
  input  logic clk_word,
  input  logic rst,
  input  logic en_a,
  input  logic en_b,
  output logic ice
);

  generate
    if (NUM_CE == 2) begin : g_dual
      logic ce1_q, ce2_q;

      always_ff @(posedge clk_word or posedge rst) begin
        if (rst) begin
          ce1_q <= 1'b0;
          ce2_q <= 1'b0;
        end else begin
          ce1_q <= en_a;
          ce2_q <= en_b;
        end
      end

      // The first enable covers the high half of the word period, the second the low half.
      assign ice = clk_word ? ce1_q : ce2_q;

      // R6
      ce_clear_chk: assert property (@(posedge clk_word)
        rst |-> (ce1_q == 1'b0 && ce2_q == 1'b0));
    end else begin : g_single
      logic unused_single;
      assign unused_single = ^{en_b, clk_word, rst};
      assign ice = en_a;
    end
  endgenerate

endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int unsigned HIST_W = 12
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              ice,
  input  logic              din,
  output logic [HIST_W-1:0] hist
);

  // The newest bit enters at index 0; index k is the bit taken k enabled edges earlier.
  always_ff @(posedge clk_bit) begin
    if (rst) begin
      hist <= '0;
    end else if (ice) begin
      hist <= {hist[HIST_W-2:0], din};
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk_bit) disable iff (rst)
    !ice |=> $stable(hist));

endmodule

// File: rtl/deser_align.sv
module deser_align #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned HIST_W = 12
) (
  input  logic              clk_word,
  input  logic              rst,
  input  logic              bitslip,
  input  logic [HIST_W-1:0] hist,
  output logic [WORD_W-1:0] q
);
  import deser_pkg::*;

  localparam int unsigned OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORD_W - 1);

  logic [OFF_W-1:0] off, off_nxt;

  always_comb begin
    off_nxt = off;
    if (bitslip) off_nxt = OFF_W'(wrap_next(32'(off), WORD_W));
  end

  // The word taken on this edge already uses the updated alignment.
  always_ff @(posedge clk_word) begin
    if (rst) begin
      off <= '0;
      q   <= '0;
    end else begin
      off <= off_nxt;
      q   <= hist[off_nxt +: WORD_W];
    end
  end

  // R3
  offset_range_chk: assert property (@(posedge clk_word) disable iff (rst)
    off <= LAST);

  // R2
  slip_step_chk: assert property (@(posedge clk_word) disable iff (rst)
    (bitslip && off != LAST) |=> off == $past(off) + OFF_W'(1));

  // R3
  slip_wrap_chk: assert property (@(posedge clk_word) disable iff (rst)
    (bitslip && off == LAST) |=> off == '0);

  // R2
  slip_idle_chk: assert property (@(posedge clk_word) disable iff (rst)
    !bitslip |=> $stable(off));

  // R8
  reset_word_chk: assert property (@(posedge clk_word)
    rst |=> q == '0);

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned NUM_CE = 2
) (
  input  logic              clk_bit,
  input  logic              clk_word,
  input  logic              rst,
  input  logic              din,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              bitslip,
  output logic [WORD_W-1:0] q
);
  import deser_pkg::*;

  localparam int unsigned HIST_W = HIST_WORDS * WORD_W;

  logic              ice;
  logic [HIST_W-1:0] hist;

  deser_enable #(.NUM_CE(NUM_CE)) u_enable (
    .clk_word (clk_word),
    .rst      (rst),
    .en_a     (en_a),
    .en_b     (en_b),
    .ice      (ice)
  );

  deser_shift #(.HIST_W(HIST_W)) u_shift (
    .clk_bit (clk_bit),
    .rst     (rst),
    .ice     (ice),
    .din     (din),
    .hist    (hist)
  );

  deser_align #(.WORD_W(WORD_W), .HIST_W(HIST_W)) u_align (
    .clk_word (clk_word),
    .rst      (rst),
    .bitslip  (bitslip),
    .hist     (hist),
    .q        (q)
  );

endmodule

// File: tb/bitslip_deser_bench.sv
module bitslip_deser_bench;
  localparam int unsigned W = 6;
  localparam int unsigned H = 2 * W;

  logic clk_bit = 1'b0, clk_word = 1'b0;
  logic rst = 1'b0, din = 1'b0, en_a = 1'b1, en_b = 1'b1, bitslip = 1'b0;
  logic [W-1:0] q_dual, q_single;
  logic [W-1:0] pat = 6'b101100;
  int unsigned idx = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // 250 MHz bit clock; word clock edges fall on bit-clock falling edges.
  always #2 clk_bit = ~clk_bit;
  initial begin #4; forever #12 clk_word = ~clk_word; end

  bitslip_deser #(.WORD_W(W), .NUM_CE(2)) u_bitslip_deser (
    .clk_bit(clk_bit), .clk_word(clk_word), .rst(rst), .din(din),
    .en_a(en_a), .en_b(en_b), .bitslip(bitslip), .q(q_dual));

  bitslip_deser #(.WORD_W(W), .NUM_CE(1)) u_bitslip_deser_single (
    .clk_bit(clk_bit), .clk_word(clk_word), .rst(rst), .din(din),
    .en_a(en_a), .en_b(en_b), .bitslip(bitslip), .q(q_single));

  // Serial source: repeating pattern, first bit from the top of pat.
  always @(negedge clk_bit) begin
    din <= pat[W-1-(idx % W)];
    idx <= idx + 1;
  end

  // Reference model built from the requirements.
  logic [H-1:0] mh_d = '0, mh_s = '0, snap_d = '0, snap_s = '0;
  logic m1 = 1'b0, m2 = 1'b0;
  int unsigned moff = 0;

  always @(posedge clk_word or posedge rst)
    if (rst) begin m1 <= 1'b0; m2 <= 1'b0; end
    else begin m1 <= en_a; m2 <= en_b; end

  always @(posedge clk_bit)
    if (rst) begin mh_d <= '0; mh_s <= '0; end
    else begin
      if (clk_word ? m1 : m2) mh_d <= {mh_d[H-2:0], din};
      if (en_a) mh_s <= {mh_s[H-2:0], din};
    end

  always @(posedge clk_word) begin
    if (rst) moff <= 0;
    else if (bitslip) moff <= (moff == W - 1) ? 0 : moff + 1;
    snap_d <= mh_d;
    snap_s <= mh_s;
  end

  function automatic logic [W-1:0] rotr(logic [W-1:0] x, int unsigned o);
    logic [2*W-1:0] d;
    d = {x, x} >> o;
    return d[W-1:0];
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic model_chk(string req);
    chk(req, q_dual, snap_d[moff +: W]);
    chk(req, q_single, snap_s[moff +: W]);
  endtask

  task automatic tick();
    @(negedge clk_word);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    logic [W-1:0] pats [3];
    logic [W-1:0] q0_d, q0_s, w_d, w_s;
    pats[0] = 6'b101100; pats[1] = 6'b110000; pats[2] = 6'b011101;

    #1 rst = 1'b1;
    repeat (4) tick();
    // R8: reset state
    chk("R8", q_dual, '0);
    chk("R8", q_single, '0);
    rst = 1'b0;

    // R6: cleared dual enable registers keep the low half idle after release
    tick();
    chk("R6", q_dual, '0);
    model_chk("R6");
    repeat (2) begin tick(); model_chk("R1"); end

    // R1 R2 R3: sweep every offset for several patterns
    for (int p = 0; p < 3; p++) begin
      pat = pats[p];
      repeat (3) tick();
      model_chk("R1");
      q0_d = q_dual;
      q0_s = q_single;
      for (int o = 1; o <= 6; o++) begin
        bitslip = 1'b1;
        tick();
        bitslip = 1'b0;
        if (o == 6) begin
          chk("R3", q_dual, q0_d);
          chk("R3", q_single, q0_s);
        end else begin
          chk("R2", q_dual, rotr(q0_d, o));
          chk("R2", q_single, rotr(q0_s, o));
        end
        model_chk("R1");
      end
    end

    // R7: no capture while the internal enable is low
    en_a = 1'b0; en_b = 1'b0;
    repeat (2) tick();
    w_d = q_dual; w_s = q_single;
    repeat (3) begin
      tick();
      chk("R7", q_dual, w_d);
      chk("R7", q_single, w_s);
    end

    // R5: each enable covers its own half of the word period
    en_a = 1'b1; en_b = 1'b0;
    repeat (4) begin tick(); model_chk("R5"); end
    en_a = 1'b0; en_b = 1'b1;
    repeat (4) begin tick(); model_chk("R5"); end

    // R4: second enable has no effect in single mode
    en_a = 1'b1; en_b = 1'b1;
    repeat (2) tick();
    w_s = q_single;
    repeat (6) begin
      en_b = ~en_b;
      tick();
      chk("R4", q_single, w_s);
      model_chk("R4");
    end

    // R8: reset in mid-run
    bitslip = 1'b1;
    tick();
    bitslip = 1'b0;
    rst = 1'b1;
    repeat (2) tick();
    chk("R8", q_dual, '0);
    chk("R8", q_single, '0);
    rst = 1'b0;
    en_b = 1'b1;
    repeat (3) begin tick(); model_chk("R8"); end

    summary();
  end

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule